// File: doc/BRIEF.md
# Multiplexed Seven-Segment Display Scanner

This block drives a bank of four common-anode seven-segment digits that share a single set of segment lines. Each digit has its own enable line, and only one digit is lit at any moment. The scanner visits the digits in turn, one slot per digit. Each slot starts with a blanking interval in which every enable is off. During that interval the new digit's pattern is placed on the shared lines, and then that digit's enable is asserted for its on-time. Because of this ordering, no digit ever shows a pattern meant for a different digit.

The caller supplies four 4-bit hex values and one decimal-point request per digit. The block converts each hex value into its segment shape. A segment or decimal point is lit by driving its line low. The slot length comes from two parameters, the on-time and the blanking length. An elaboration check makes sure that a full pass over all digits fits inside the period of the minimum frame refresh rate for the given clock frequency.

Top module: `seg_scan_driver`

## Requirements
- R1: While reset is high, and in the first cycle after its release, all digit enables are low, all seven segment lines are high (0x7F) and the decimal-point line is high.
- R2: At most one bit of `dig_en_o` is high in any cycle.
- R3: The lit digit order after reset is bit 0, bit 1, bit 2, bit 3, then bit 0 again. Each new enable is the previous one rotated left by one position.
- R4: Each enable stays high for exactly CYCLES_PER_DIGIT consecutive cycles. A slot lasts BLANK_CYCLES + CYCLES_PER_DIGIT cycles.
- R5: Before every rising enable, all enables are low for exactly BLANK_CYCLES consecutive cycles.
- R6: The segment and decimal-point lines change only in a cycle in which all enables are low and were also low in the previous cycle. Within a slot they change at most once, at the end of the first blanking cycle.
- R7: `seg_n_o` is ordered {g,f,e,d,c,b,a} from bit 6 down to bit 0, and a lit segment is 0. The lit patterns (active-high, gfedcba) for hex values 0 to F are: 3F, 06, 5B, 4F, 66, 6D, 7D, 07, 7F, 6F, 77, 7C (lowercase b), 39, 5E (lowercase d), 79, 71.
- R8: Digit k is the value in `digits_i[4k+3:4k]`, and its enable is bit k of `dig_en_o`. `dp_n_o` is low during digit k's slot exactly when `dots_i[k]` was high at the load point.
- R9: Digit values and dot requests are sampled once per slot, at the clock edge that ends the first blanking cycle. Changes after that point do not affect the lines until the next slot.
- R10: One full frame, NUM_DIGITS x (BLANK_CYCLES + CYCLES_PER_DIGIT) cycles, is no longer than CLK_HZ / MIN_FRAME_HZ cycles. BLANK_CYCLES is at least 2, and parameter sets that break either rule fail elaboration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| digits_i | input | 16 | Four hex digit values, digit k in bits 4k+3:4k |
| dots_i | input | 4 | Decimal-point request per digit, bit k for digit k |
| seg_n_o | output | 7 | Shared segment lines {g,f,e,d,c,b,a}, active low |
| dp_n_o | output | 1 | Shared decimal-point line, active low |
| dig_en_o | output | 4 | One-hot digit enable, active high |

## Verification
The bound checker watches the timing skeleton on every cycle:
- that at most one enable is high,
- that each new enable is the left rotation of the last one,
- the exact lengths of the on-times and blanking runs,
- that the shared lines move only when the enables have been dark for two cycles,
- the reset values.

The bench scenarios are needed for everything else. They show that the shape on the lines matches the hex value and dot request of the digit being lit, and that a value changed mid-slot stays invisible until the next slot. They also show that a whole frame repeats at the required rate.

// File: rtl/seg_scan_pkg.sv
package seg_scan_pkg;

   localparam int unsigned SEG_W = 7;
   localparam int unsigned HEX_W = 4;

   typedef logic [SEG_W-1:0] seg_t;

   // Lit (active-high) shape for one hex value, bit order {g,f,e,d,c,b,a}
   function automatic seg_t hex_shape(input logic [HEX_W-1:0] v);
      seg_t s;
      unique case (v)
         4'h0: s = 7'b011_1111;
         4'h1: s = 7'b000_0110;
         4'h2: s = 7'b101_1011;
         4'h3: s = 7'b100_1111;
         4'h4: s = 7'b110_0110;
         4'h5: s = 7'b110_1101;
         4'h6: s = 7'b111_1101;
         4'h7: s = 7'b000_0111;
         4'h8: s = 7'b111_1111;
         4'h9: s = 7'b110_1111;
         4'hA: s = 7'b111_0111;
         4'hB: s = 7'b111_1100;
         4'hC: s = 7'b011_1001;
         4'hD: s = 7'b101_1110;
         4'hE: s = 7'b111_1001;
         default: s = 7'b111_0001;
      endcase
      return s;
   endfunction

endpackage

// File: rtl/scan_slot_timer.sv
// Counts the cycles of one digit slot: blanking cycles first, then on-time.
module scan_slot_timer #(
   parameter int unsigned BLANK_CYCLES     = 2,
   parameter int unsigned CYCLES_PER_DIGIT = 4
) (
   input  logic clk_i,
   input  logic rst_i,
   output logic slot_end_o,   // current cycle is the last of the slot
   output logic load_o,       // current cycle is the first blanking cycle
   output logic lit_next_o    // next cycle belongs to the on-time
);

   localparam int unsigned SLOT_LEN = BLANK_CYCLES + CYCLES_PER_DIGIT;
   localparam int unsigned CNT_W    = (SLOT_LEN > 2) ? $clog2(SLOT_LEN) : 2;
   localparam logic [CNT_W-1:0] LAST_IDX  = CNT_W'(SLOT_LEN - 1);
   localparam logic [CNT_W-1:0] FIRST_LIT = CNT_W'(BLANK_CYCLES);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;

   always_comb begin
      slot_end_o = (cnt_q == LAST_IDX);
      cnt_d      = slot_end_o ? '0 : cnt_q + 1'b1;
      load_o     = (cnt_q == '0);
      lit_next_o = (cnt_d >= FIRST_LIT);
   end

   always_ff @(posedge clk_i) begin
      if (rst_i) cnt_q <= '0;
      else       cnt_q <= cnt_d;
   end

endmodule

// File: rtl/digit_ring.sv
// One-hot ring that selects the current digit; rotates left once per slot.
module digit_ring #(
   parameter int unsigned NUM_DIGITS = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  advance_i,
   output logic [NUM_DIGITS-1:0] ring_o
);

   localparam logic [NUM_DIGITS-1:0] RING_INIT = NUM_DIGITS'(1);

   logic [NUM_DIGITS-1:0] ring_q;

   generate
      if (NUM_DIGITS == 1) begin : g_single
         always_ff @(posedge clk_i) ring_q <= RING_INIT;
      end else begin : g_rotate
         always_ff @(posedge clk_i) begin
            if (rst_i)          ring_q <= RING_INIT;
            else if (advance_i) ring_q <= {ring_q[NUM_DIGITS-2:0], ring_q[NUM_DIGITS-1]};
         end
      end
   endgenerate

   assign ring_o = ring_q;

endmodule

// File: rtl/digit_select.sv
// AND-OR selection of the digit value and dot request named by the one-hot ring.
module digit_select #(
   parameter int unsigned NUM_DIGITS = 4,
   parameter int unsigned VAL_W      = 4
) (
   input  logic [NUM_DIGITS-1:0]       ring_i,
   input  logic [NUM_DIGITS*VAL_W-1:0] digits_i,
   input  logic [NUM_DIGITS-1:0]       dots_i,
   output logic [VAL_W-1:0]            val_o,
   output logic                        dot_o
);

   logic [VAL_W-1:0] masked [NUM_DIGITS];

   generate
      for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_mask
         assign masked[k] = digits_i[k*VAL_W +: VAL_W] & {VAL_W{ring_i[k]}};
      end
   endgenerate

   always_comb begin
      val_o = '0;
      for (int k = 0; k < NUM_DIGITS; k++) val_o = val_o | masked[k];
      dot_o = |(dots_i & ring_i);
   end

endmodule

// File: rtl/seg_out_stage.sv
// Output registers: enables follow the slot phase; the pattern loads once per slot.
module seg_out_stage
   import seg_scan_pkg::*;
#(
   parameter int unsigned NUM_DIGITS = 4
) (
   input  logic                  clk_i,
   input  logic                  rst_i,
   input  logic                  load_i,
   input  logic                  lit_next_i,
   input  logic [NUM_DIGITS-1:0] ring_i,
   input  logic [HEX_W-1:0]      val_i,
   input  logic                  dot_i,
   output logic [SEG_W-1:0]      seg_n_o,
   output logic                  dp_n_o,
   output logic [NUM_DIGITS-1:0] en_o
);

   seg_t                  seg_q;
   logic                  dp_q;
   logic [NUM_DIGITS-1:0] en_q;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         en_q  <= '0;
         seg_q <= '1;
         dp_q  <= 1'b1;
      end else begin
         en_q <= lit_next_i ? ring_i : '0;
         if (load_i) begin
            seg_q <= ~hex_shape(val_i);
            dp_q  <= ~dot_i;
         end
      end
   end

   assign seg_n_o = seg_q;
   assign dp_n_o  = dp_q;
   assign en_o    = en_q;

endmodule

// File: rtl/seg_scan_driver.sv
module seg_scan_driver
   import seg_scan_pkg::*;
#(
   parameter int unsigned NUM_DIGITS       = 4,
   parameter int unsigned CLK_HZ           = 250_000_000,
   parameter int unsigned MIN_FRAME_HZ     = 30,
   parameter int unsigned CYCLES_PER_DIGIT = 1_000_000,
   parameter int unsigned BLANK_CYCLES     = 16
) (
   input  logic                        clk_i,
   input  logic                        rst_i,
   input  logic [NUM_DIGITS*HEX_W-1:0] digits_i,
   input  logic [NUM_DIGITS-1:0]       dots_i,
   output logic [SEG_W-1:0]            seg_n_o,
   output logic                        dp_n_o,
   output logic [NUM_DIGITS-1:0]       dig_en_o
);

   localparam longint unsigned SLOT_LEN    = longint'(BLANK_CYCLES) + longint'(CYCLES_PER_DIGIT);
   localparam longint unsigned FRAME_LEN   = longint'(NUM_DIGITS) * SLOT_LEN;
   localparam longint unsigned FRAME_LIMIT = longint'(CLK_HZ) / longint'(MIN_FRAME_HZ);

   // R10: parameter legality, checked at elaboration
   generate
      if (NUM_DIGITS != 4) begin : g_bad_digits
         $error("seg_scan_driver: NUM_DIGITS must be 4");
      end
      if (BLANK_CYCLES < 2) begin : g_bad_blank
         $error("seg_scan_driver: BLANK_CYCLES must be at least 2");
      end
      if (CYCLES_PER_DIGIT < 1) begin : g_bad_on
         $error("seg_scan_driver: CYCLES_PER_DIGIT must be at least 1");
      end
      if (MIN_FRAME_HZ == 0 || FRAME_LEN > FRAME_LIMIT) begin : g_bad_rate
         $error("seg_scan_driver: frame longer than the minimum refresh period");
      end
   endgenerate

   logic                  slot_end;
   logic                  load;
   logic                  lit_next;
   logic [NUM_DIGITS-1:0] ring;
   logic [HEX_W-1:0]      sel_val;
   logic                  sel_dot;

   scan_slot_timer #(
      .BLANK_CYCLES     (BLANK_CYCLES),
      .CYCLES_PER_DIGIT (CYCLES_PER_DIGIT)
   ) u_timer (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .slot_end_o (slot_end),
      .load_o     (load),
      .lit_next_o (lit_next)
   );

   digit_ring #(
      .NUM_DIGITS (NUM_DIGITS)
   ) u_ring (
      .clk_i     (clk_i),
      .rst_i     (rst_i),
      .advance_i (slot_end),
      .ring_o    (ring)
   );

   digit_select #(
      .NUM_DIGITS (NUM_DIGITS),
      .VAL_W      (HEX_W)
   ) u_select (
      .ring_i   (ring),
      .digits_i (digits_i),
      .dots_i   (dots_i),
      .val_o    (sel_val),
      .dot_o    (sel_dot)
   );

   seg_out_stage #(
      .NUM_DIGITS (NUM_DIGITS)
   ) u_out (
      .clk_i      (clk_i),
      .rst_i      (rst_i),
      .load_i     (load),
      .lit_next_i (lit_next),
      .ring_i     (ring),
      .val_i      (sel_val),
      .dot_i      (sel_dot),
      .seg_n_o    (seg_n_o),
      .dp_n_o     (dp_n_o),
      .en_o       (dig_en_o)
   );

endmodule

// File: rtl/seg_scan_checker.sv
module seg_scan_checker #(
   parameter int unsigned NUM_DIGITS       = 4,
   parameter int unsigned CYCLES_PER_DIGIT = 4,
   parameter int unsigned BLANK_CYCLES     = 2
) (
   input logic                  clk_i,
   input logic                  rst_i,
   input logic [6:0]            seg_n_o,
   input logic                  dp_n_o,
   input logic [NUM_DIGITS-1:0] dig_en_o
);

   int unsigned           on_run;
   int unsigned           dark_run;
   logic [NUM_DIGITS-1:0] last_en;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         on_run   <= 0;
         dark_run <= 0;
         last_en  <= NUM_DIGITS'(1) << (NUM_DIGITS - 1);
      end else begin
         on_run   <= (dig_en_o != '0) ? on_run + 1 : 0;
         dark_run <= (dig_en_o == '0) ? dark_run + 1 : 0;
         if (dig_en_o != '0) last_en <= dig_en_o;
      end
   end

   // R1: reset values
   a_r1_reset_dark: assert property (@(posedge clk_i)
      rst_i |=> (dig_en_o == '0 && seg_n_o == 7'h7F && dp_n_o));

   // R2: at most one digit lit
   a_r2_single_enable: assert property (@(posedge clk_i) disable iff (rst_i)
      $onehot0(dig_en_o));

   // R3: each new enable is the last one rotated left
   a_r3_rotate_left: assert property (@(posedge clk_i) disable iff (rst_i)
      (dig_en_o != '0 && $past(dig_en_o) == '0)
         |-> dig_en_o == {last_en[NUM_DIGITS-2:0], last_en[NUM_DIGITS-1]});

   // R4: on-time length
   a_r4_on_time: assert property (@(posedge clk_i) disable iff (rst_i)
      (dig_en_o == '0 && $past(dig_en_o) != '0) |-> on_run == CYCLES_PER_DIGIT);

   // R5: blanking length before each enable
   a_r5_blank_time: assert property (@(posedge clk_i) disable iff (rst_i)
      (dig_en_o != '0 && $past(dig_en_o) == '0) |-> dark_run == BLANK_CYCLES);

   // R6: lines move only after a full dark cycle
   a_r6_lines_move_dark: assert property (@(posedge clk_i) disable iff (rst_i)
      !$stable({dp_n_o, seg_n_o}) |-> (dig_en_o == '0 && $past(dig_en_o) == '0));

endmodule

bind seg_scan_driver seg_scan_checker #(
   .NUM_DIGITS       (NUM_DIGITS),
   .CYCLES_PER_DIGIT (CYCLES_PER_DIGIT),
   .BLANK_CYCLES     (BLANK_CYCLES)
) u_seg_scan_checker (
   .clk_i    (clk_i),
   .rst_i    (rst_i),
   .seg_n_o  (seg_n_o),
   .dp_n_o   (dp_n_o),
   .dig_en_o (dig_en_o)
);

// File: tb/test_seg_scan_driver.sv
module test_seg_scan_driver;

   localparam int ND     = 4;
   localparam int ON_C   = 5;
   localparam int BL_C   = 3;
   localparam int SLOT   = ON_C + BL_C;
   localparam int CLKHZ  = 250_000_000;
   localparam int MINHZ  = 30;

   logic          clk = 1'b0;
   logic          rst = 1'b1;
   logic [15:0]   digits = '0;
   logic [3:0]    dots = '0;
   logic [6:0]    seg_n;
   logic          dp_n;
   logic [3:0]    en;

   int   n_chk = 0;
   int   n_bad = 0;
   int   t = 0;
   int   last_rise = -1;
   bit   finished = 1'b0;
   logic [6:0] exp_seg = 7'h7F;
   logic       exp_dp = 1'b1;

   always #2 clk = ~clk;

   seg_scan_driver #(
      .NUM_DIGITS       (ND),
      .CLK_HZ           (CLKHZ),
      .MIN_FRAME_HZ     (MINHZ),
      .CYCLES_PER_DIGIT (ON_C),
      .BLANK_CYCLES     (BL_C)
   ) i_seg_scan_driver (
      .clk_i    (clk),
      .rst_i    (rst),
      .digits_i (digits),
      .dots_i   (dots),
      .seg_n_o  (seg_n),
      .dp_n_o   (dp_n),
      .dig_en_o (en)
   );

   // R7 shapes, active-high gfedcba
   function automatic logic [6:0] ref_shape(input logic [3:0] v);
      case (v)
         4'h0: return 7'h3F;  4'h1: return 7'h06;  4'h2: return 7'h5B;  4'h3: return 7'h4F;
         4'h4: return 7'h66;  4'h5: return 7'h6D;  4'h6: return 7'h7D;  4'h7: return 7'h07;
         4'h8: return 7'h7F;  4'h9: return 7'h6F;  4'hA: return 7'h77;  4'hB: return 7'h7C;
         4'hC: return 7'h39;  4'hD: return 7'h5E;  4'hE: return 7'h79;  default: return 7'h71;
      endcase
   endfunction

   // R3/R4/R5 expected enable after tt edges since reset release
   function automatic logic [3:0] ref_en(input int tt);
      if ((tt % SLOT) < BL_C) return 4'b0000;
      return 4'b0001 << ((tt / SLOT) % ND);
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s t=%0d actual=%h expected=%h", tag, t, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      repeat (3) begin
         @(negedge clk);
         chk("R1 enables in reset", 32'(en), 32'h0);
         chk("R1 segments in reset", 32'(seg_n), 32'h7F);
         chk("R1 dot in reset", 32'(dp_n), 32'h1);
      end
      rst = 1'b0;
      t = 0;
      last_rise = -1;
      exp_seg = 7'h7F;
      exp_dp = 1'b1;
   endtask

   // chg_pct: chance per cycle of new random inputs (mid-slot changes exercise R9)
   task automatic run(input int ncyc, input int chg_pct);
      for (int i = 0; i < ncyc; i++) begin
         logic [3:0] prev_en;
         prev_en = en;
         @(posedge clk);
         t++;
         if ((t % SLOT) == 1) begin
            int dg;
            dg = (t / SLOT) % ND;
            exp_seg = ~ref_shape(digits[dg*4 +: 4]);
            exp_dp  = ~dots[dg];
         end
         @(negedge clk);
         chk("R2/R3/R4/R5 enable", 32'(en), 32'(ref_en(t)));
         chk("R6/R7/R9 segments", 32'(seg_n), 32'(exp_seg));
         chk("R8 dot", 32'(dp_n), 32'(exp_dp));
         if (t == 1) chk("R1 first cycle dark", 32'(en), 32'h0);
         if (en[0] && !prev_en[0]) begin
            if (last_rise >= 0) begin
               chk("R10 frame period", 32'(t - last_rise), 32'(ND * SLOT));
               chk("R10 frame within limit", 32'((t - last_rise) <= CLKHZ / MINHZ), 32'h1);
            end
            last_rise = t;
         end
         if (chg_pct > 0 && int'($urandom_range(99)) < chg_pct) begin
            digits = 16'($urandom);
            dots   = 4'($urandom);
         end
      end
   endtask

   initial begin
      void'($urandom(32'd20240611));
      do_reset();
      // R7: every hex value shown, R8 dot patterns
      digits = 16'h3210; dots = 4'b0000; run(ND*SLOT*2, 0);
      digits = 16'h7654; dots = 4'b1111; run(ND*SLOT*2, 0);
      digits = 16'hBA98; dots = 4'b0101; run(ND*SLOT*2, 0);
      digits = 16'hFEDC; dots = 4'b1010; run(ND*SLOT*2, 0);
      // R9: change values just after the load point, must stay invisible this slot
      while ((t % SLOT) != 2) run(1, 0);
      digits = 16'h8888; dots = 4'b1111;
      run(SLOT - 2, 0);
      // random mix with frequent mid-slot changes
      run(1200, 30);
      // reset in the middle of a slot (R1)
      while ((t % SLOT) != 5) run(1, 0);
      do_reset();
      run(600, 10);
      finished = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog expired t=%0d actual=running expected=done", t);
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

endmodule